// File: doc/BRIEF.md
# Two-Bank SDRAM Write Sequencer

This block turns write requests into command, address, bank and data pin activity for a synchronous DRAM with two banks. A request names a bank, a row, a start column, one full burst of data and an auto-precharge flag. The sequencer opens rows, writes bursts and closes rows. A row is closed either by an explicit precharge or by the device's own precharge, which the auto-precharge flag requests. Each bank has its own activate-to-write, write-recovery and precharge timers, so work on one bank can run while the other bank is still streaming data or recovering.

The controller is a four-state machine. `S_IDLE` holds the request port ready. On acceptance it takes one of three transitions. *open-miss* goes to `S_ACT` when the bank is closed. *row-conflict* goes to `S_PRE` when a different row is open. *row-hit* goes to `S_WR` when the requested row is already open. In `S_PRE` the *precharge-issued* transition moves to `S_ACT`. In `S_ACT` the *activate-issued* transition moves to `S_WR`. In `S_WR` the *write-issued* transition returns to `S_IDLE`. Each state waits, sending NOP, until the target bank's timers, and for a write the data path, permit its command. The command pins are registered, so a command appears on the pins one cycle after the machine decides it. When requests alternate between banks, the next bank's activate goes out while the current burst is still on the data bus. This hides that bank's precharge and recovery time.

Top module: `sdram_wr_seq`

## Requirements
- R1: After reset the pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), dq_oe is low and req_ready is high.
- R2: A request to a closed bank produces ACT (0011), with the row on addr and the bank on ba. WRITE (0100) follows exactly T_RCD cycles later when nothing else delays it.
- R3: WRITE carries the start column on addr[COL_W-1:0], the auto-precharge flag on addr[AP_BIT] (bit 10) and zero on all other address bits. Data word 0 (req_data[DATA_W-1:0]) is on dq in the WRITE cycle. Word i (req_data[i*DATA_W +: DATA_W]) follows on each of the next BL-1 cycles, and dq_oe is high in exactly those BL cycles.
- R4: A request to the row already open in its bank produces WRITE with no ACT or PRE. Placed behind a burst, it starts exactly BL cycles after the previous WRITE, so the data bus has no gap.
- R5: A request for a different row in an open bank produces PRE (0010, addr all zero) to that bank no earlier than BL-1+T_WR cycles after that bank's last WRITE. ACT follows exactly T_RP cycles after PRE, and WRITE follows T_RCD cycles after ACT.
- R6: After a WRITE with the auto-precharge flag, the bank is treated as closed and no PRE is sent to it. Its next ACT comes no earlier than BL-1+T_WR+T_RP cycles after that WRITE.
- R7: A request to the other bank is accepted while a burst is still streaming. Its ACT is issued during that burst, and its WRITE follows the previous WRITE with no idle data cycle.
- R8: Every cycle without a decided command shows NOP on the pins.
- R9: req_ready is high only in the idle state and drops for the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_bank | input | 1 | Target bank |
| req_row | input | ADDR_W | Row address |
| req_col | input | COL_W | Burst start column |
| req_ap | input | 1 | Close the row by auto-precharge after this write |
| req_data | input | BL*DATA_W | Burst data, word 0 in the low bits |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Multiplexed address |
| sd_ba | output | 1 | Bank select |
| sd_dq | output | DATA_W | Write data |
| sd_dq_oe | output | 1 | Data bus drive enable |

## Verification
A decision reaches the pins one register later, so each command's cycle is checked as the distance in cycles from the previous command on the pins. That distance is T_RCD from ACT to WRITE, T_RP from PRE to ACT, BL between hit or interleaved writes, BL-1+T_WR from a write to a following PRE, and BL-1+T_WR+T_RP from an auto-precharge write to the next ACT. These distances hold because the stimulus presents each next request while the previous one is being served. Data words are due in the WRITE cycle and the BL-1 cycles after it, and dq_oe is checked in every monitored cycle against a burst window that the bench opens when it sees WRITE. All sampling is done on the falling edge.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;
    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_PRE   = 4'b0010,
        CMD_NOP   = 4'b0111
    } sd_cmd_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PRE,
        S_ACT,
        S_WR
    } seq_state_e;
endpackage

// File: rtl/bank_timer.sv
module bank_timer #(
    parameter int ROW_W = 11,
    parameter int BL    = 4,
    parameter int T_RCD = 2,
    parameter int T_WR  = 2,
    parameter int T_RP  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_wr,
    input  logic             do_pre,
    input  logic             wr_ap,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             rcd_ok,
    output logic             wr_ok,
    output logic             rp_ok
);
    localparam int WR_LD = BL - 1 + T_WR - 1;
    localparam int AP_LD = BL - 1 + T_WR + T_RP - 1;
    localparam int CW    = $clog2(AP_LD + 2);

    logic [CW-1:0]    rcd_cnt, wr_cnt, rp_cnt;
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcd_cnt <= '0;
            wr_cnt  <= '0;
            rp_cnt  <= '0;
            open_q  <= 1'b0;
            row_q   <= '0;
        end else begin
            if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - CW'(1);
            if (wr_cnt  != '0) wr_cnt  <= wr_cnt  - CW'(1);
            if (rp_cnt  != '0) rp_cnt  <= rp_cnt  - CW'(1);
            if (do_act) begin
                rcd_cnt <= CW'(T_RCD - 1);
                open_q  <= 1'b1;
                row_q   <= row_in;
            end
            if (do_wr) begin
                wr_cnt <= CW'(WR_LD);
                if (wr_ap) begin
                    // internal precharge starts tWR after the last word
                    open_q <= 1'b0;
                    rp_cnt <= CW'(AP_LD);
                end
            end
            if (do_pre) begin
                open_q <= 1'b0;
                rp_cnt <= CW'(T_RP - 1);
            end
        end
    end

    assign is_open  = open_q;
    assign open_row = row_q;
    assign rcd_ok   = (rcd_cnt == '0);
    assign wr_ok    = (wr_cnt == '0);
    assign rp_ok    = (rp_cnt == '0);

    p_wr_after_rcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        do_wr |-> (open_q && rcd_cnt == '0))
        else $error("write issued before activate delay elapsed");

    p_pre_after_recovery_r5: assert property (@(posedge clk) disable iff (!rst_n)
        do_pre |-> (open_q && wr_cnt == '0))
        else $error("precharge issued inside write recovery");

    p_act_after_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (!open_q && rp_cnt == '0))
        else $error("activate issued to open or precharging bank");
endmodule

// File: rtl/burst_shifter.sv
module burst_shifter #(
    parameter int DATA_W = 16,
    parameter int BL     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [BL*DATA_W-1:0] load_data,
    output logic [DATA_W-1:0]    word,
    output logic                 oe,
    output logic                 can_load
);
    localparam int RW = $clog2(BL + 1);

    logic [BL*DATA_W-1:0] buf_q;
    logic [RW-1:0]        rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            buf_q <= load_data;
            rem_q <= RW'(BL);
        end else if (rem_q != '0) begin
            buf_q <= buf_q >> DATA_W;
            rem_q <= rem_q - RW'(1);
        end
    end

    assign word     = buf_q[DATA_W-1:0];
    assign oe       = (rem_q != '0);
    assign can_load = (rem_q <= RW'(1));

    p_load_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (rem_q <= RW'(1)))
        else $error("burst loaded over a running burst");
endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
    import sdram_wr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int COL_W  = 8,
    parameter int AP_BIT = 10,
    parameter int DATA_W = 16,
    parameter int BL     = 4,
    parameter int T_RCD  = 2,
    parameter int T_WR   = 2,
    parameter int T_RP   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_bank,
    input  logic [ADDR_W-1:0]    req_row,
    input  logic [COL_W-1:0]     req_col,
    input  logic                 req_ap,
    input  logic [BL*DATA_W-1:0] req_data,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [ADDR_W-1:0]    sd_addr,
    output logic                 sd_ba,
    output logic [DATA_W-1:0]    sd_dq,
    output logic                 sd_dq_oe
);
    localparam int NBANK = 2;

    seq_state_e state_q, state_d;
    sd_cmd_e    cmd_d, cmd_q;

    logic                 h_bank, h_ap;
    logic [ADDR_W-1:0]    h_row;
    logic [COL_W-1:0]     h_col;
    logic [BL*DATA_W-1:0] h_data;

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic              ba_q;

    logic [NBANK-1:0]  bk_open, bk_rcd_ok, bk_wr_ok, bk_rp_ok;
    logic [ADDR_W-1:0] bk_row [NBANK];
    logic              can_load;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_timer #(
            .ROW_W(ADDR_W), .BL(BL), .T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP)
        ) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .do_act   (cmd_d == CMD_ACT   && h_bank == 1'(b)),
            .do_wr    (cmd_d == CMD_WRITE && h_bank == 1'(b)),
            .do_pre   (cmd_d == CMD_PRE   && h_bank == 1'(b)),
            .wr_ap    (h_ap),
            .row_in   (h_row),
            .is_open  (bk_open[b]),
            .open_row (bk_row[b]),
            .rcd_ok   (bk_rcd_ok[b]),
            .wr_ok    (bk_wr_ok[b]),
            .rp_ok    (bk_rp_ok[b])
        );
    end

    burst_shifter #(.DATA_W(DATA_W), .BL(BL)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cmd_d == CMD_WRITE),
        .load_data (h_data),
        .word      (sd_dq),
        .oe        (sd_dq_oe),
        .can_load  (can_load)
    );

    // state register and held request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            h_bank  <= 1'b0;
            h_ap    <= 1'b0;
            h_row   <= '0;
            h_col   <= '0;
            h_data  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid) begin
                h_bank <= req_bank;
                h_ap   <= req_ap;
                h_row  <= req_row;
                h_col  <= req_col;
                h_data <= req_data;
            end
        end
    end

    // transitions and command decision
    always_comb begin
        state_d = state_q;
        cmd_d   = CMD_NOP;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (!bk_open[req_bank])                 state_d = S_ACT; // open-miss
                    else if (bk_row[req_bank] != req_row)   state_d = S_PRE; // row-conflict
                    else                                    state_d = S_WR;  // row-hit
                end
            end
            S_PRE: begin
                if (bk_wr_ok[h_bank] && bk_rp_ok[h_bank]) begin
                    cmd_d   = CMD_PRE;
                    state_d = S_ACT;  // precharge-issued
                end
            end
            S_ACT: begin
                if (bk_rp_ok[h_bank]) begin
                    cmd_d   = CMD_ACT;
                    state_d = S_WR;   // activate-issued
                end
            end
            S_WR: begin
                if (bk_rcd_ok[h_bank] && can_load) begin
                    cmd_d   = CMD_WRITE;
                    state_d = S_IDLE; // write-issued
                end
            end
        endcase
    end

    always_comb begin
        addr_d = '0;
        if (cmd_d == CMD_ACT) begin
            addr_d = h_row;
        end else if (cmd_d == CMD_WRITE) begin
            addr_d[COL_W-1:0] = h_col;
            addr_d[AP_BIT]    = h_ap;
        end
    end

    // registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            ba_q   <= 1'b0;
        end else begin
            cmd_q  <= cmd_d;
            addr_q <= addr_d;
            if (cmd_d != CMD_NOP) ba_q <= h_bank;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_addr   = addr_q;
    assign sd_ba     = ba_q;
    assign req_ready = (state_q == S_IDLE);

    p_idle_drives_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> (cmd_q == CMD_NOP))
        else $error("command left idle state");

    p_write_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_WRITE) |-> sd_dq_oe)
        else $error("write without first data word");

    p_ready_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready)
        else $error("ready held after accept");
endmodule

// File: tb/test_sdram_wr_seq.sv
`timescale 1ns/1ps
module test_sdram_wr_seq;
    localparam int ADDR_W = 11, COL_W = 8, AP_BIT = 10, DATA_W = 16;
    localparam int BL = 4, T_RCD = 2, T_WR = 2, T_RP = 3;
    localparam logic [3:0] C_ACT = 4'b0011, C_WR = 4'b0100, C_PRE = 4'b0010, C_NOP = 4'b0111;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_bank = 1'b0, req_ap = 1'b0;
    logic [ADDR_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [BL*DATA_W-1:0] req_data = '0;
    logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_dq_oe;
    logic [ADDR_W-1:0] sd_addr;
    logic [DATA_W-1:0] sd_dq;

    always #4 clk = ~clk;

    sdram_wr_seq i_sdram_wr_seq (.*);

    typedef struct {
        logic [3:0]        cmd;
        logic              ba;
        logic [ADDR_W-1:0] addr;
        int                gap;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    logic [DATA_W-1:0] dat_q[$];
    int  n_chk = 0, n_bad = 0;
    int  cyc = 0, last_cmd = 0, burst_left = 0;
    bit  mon_en = 0, done = 0;
    bit  m_open [2];
    logic [ADDR_W-1:0] m_row [2];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push_cmd(input logic [3:0] c, input logic b, input logic [ADDR_W-1:0] a,
                            input int g, input string t);
        exp_t e;
        e.cmd = c; e.ba = b; e.addr = a; e.gap = g; e.tag = t;
        exp_q.push_back(e);
    endtask

    // driver: model the bank state, push expected commands and data, then hand over
    task automatic send(input logic b, input int row, input int col, input logic ap,
                        input int first_gap, input string t);
        logic [ADDR_W-1:0] wa;
        wa = ADDR_W'(col);
        wa[AP_BIT] = ap;
        if (m_open[b] && m_row[b] != ADDR_W'(row)) begin
            push_cmd(C_PRE, b, '0, first_gap, "R5");
            push_cmd(C_ACT, b, ADDR_W'(row), T_RP, "R5");
            push_cmd(C_WR, b, wa, T_RCD, "R5");
        end else if (!m_open[b]) begin
            push_cmd(C_ACT, b, ADDR_W'(row), first_gap, t);
            push_cmd(C_WR, b, wa, T_RCD, "R2");
        end else begin
            push_cmd(C_WR, b, wa, first_gap, t);
        end
        m_open[b] = !ap;
        m_row[b]  = ADDR_W'(row);
        @(negedge clk);
        for (int i = 0; i < BL; i++) begin
            logic [DATA_W-1:0] w;
            w = DATA_W'((int'(b) << 15) | (row << 8) | (col << 2) | i);
            req_data[i*DATA_W +: DATA_W] = w;
            dat_q.push_back(w);
        end
        req_valid = 1'b1; req_bank = b; req_row = ADDR_W'(row);
        req_col = COL_W'(col); req_ap = ap;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (mon_en) begin
            logic [3:0] c;
            bit w, exp_oe;
            cyc++;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            w = (c == C_WR);
            exp_oe = w || (burst_left > 0);
            check(sd_dq_oe == exp_oe, "R3 dq_oe", 32'(sd_dq_oe), 32'(exp_oe));
            if (sd_dq_oe && exp_oe) begin
                if (dat_q.size() == 0) check(1'b0, "R3 unexpected data", 32'(sd_dq), 0);
                else begin
                    logic [DATA_W-1:0] d;
                    d = dat_q.pop_front();
                    check(sd_dq == d, "R3 data", 32'(sd_dq), 32'(d));
                end
            end
            if (c != C_NOP) begin
                if (exp_q.size() == 0) check(1'b0, "R8 unexpected command", 32'(c), 32'(C_NOP));
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(c == e.cmd, {e.tag, " command"}, 32'(c), 32'(e.cmd));
                    check(sd_ba == e.ba, {e.tag, " bank"}, 32'(sd_ba), 32'(e.ba));
                    check(sd_addr == e.addr, {e.tag, " address"}, 32'(sd_addr), 32'(e.addr));
                    if (e.gap >= 0)
                        check(cyc - last_cmd == e.gap, {e.tag, " spacing"}, 32'(cyc - last_cmd), 32'(e.gap));
                end
                last_cmd = cyc;
            end
            burst_left = w ? BL - 1 : (burst_left > 0 ? burst_left - 1 : 0);
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_open[0] = 0; m_open[1] = 0; m_row[0] = '0; m_row[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 command", 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(C_NOP));
        check(sd_dq_oe == 1'b0, "R1 dq_oe", 32'(sd_dq_oe), 0);
        check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
        mon_en = 1;
        // R2 closed bank, then R7 interleave onto the other bank
        send(1'b0, 5, 3, 1'b0, -1, "R2");
        send(1'b1, 7, 9, 1'b1, 2, "R7");
        // R4 row hit right behind the interleaved burst
        send(1'b0, 5, 20, 1'b0, BL, "R4");
        // R6 reactivation after auto-precharge
        send(1'b1, 7, 1, 1'b0, (BL - 1 + T_WR + T_RP) - BL, "R6");
        // R5 row conflict right after a write to the same bank
        send(1'b1, 9, 2, 1'b0, BL - 1 + T_WR, "R5");
        // R5 row conflict on a long-recovered bank, with auto-precharge
        send(1'b0, 2, 5, 1'b1, 2, "R5");
        @(negedge clk);
        req_valid = 1'b0;
        // R9 ready low while the held request is served
        check(req_ready == 1'b0, "R9 ready while busy", 32'(req_ready), 0);
        repeat (30) @(negedge clk);
        // R6 bank closed by auto-precharge: expects ACT, no PRE
        send(1'b0, 2, 6, 1'b0, -1, "R6");
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        // R8 idle: all expected commands consumed, nothing extra
        check(exp_q.size() == 0, "R8 pending commands", 32'(exp_q.size()), 0);
        check(dat_q.size() == 0, "R3 pending data", 32'(dat_q.size()), 0);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R8 idle NOP", 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(C_NOP));
        check(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule